// File: doc/BRIEF.md
# Annunciator-Driven ROM Page Selector

This block chooses which of four 12 KB ROM banks the processor sees in the upper address window, from 0xD000 up to 0xFFFF. The page number has two bits. Each bit has its own pair of I/O locations: touching one location clears the bit and touching the other sets it. These locations also act as annunciator controls. A read or a write to one of them counts as a touch, and a read of one returns zero on the data bus.

Each bank is built from six ROM chips. Every chip contributes one 2 KB slice, and the slices sit in chip order, so the lowest 2 KB of the window comes from chip 0 and the highest from chip 5. A chip is either 4 KB or 8 KB. For bank j, the slice taken from a chip starts at (j × 2 KB) modulo that chip's size. A 4 KB chip therefore repeats its two slices across the four banks.

For every address in the window, the block gives three outputs:
- the flat physical ROM address;
- a one-hot select for the chip that holds the byte;
- the byte address inside that chip.

The chip storage itself sits outside the block.

Top module: `rom_page_sel`

## Requirements
- R1: While reset is asserted and after it is released, the active page is 0.
- R2: A read or write strobe at 0xC058 clears page bit 0 and one at 0xC059 sets it, effective from the next clock, leaving page bit 1 unchanged.
- R3: A read or write strobe at 0xC05A clears page bit 1 and one at 0xC05B sets it, effective from the next clock, leaving page bit 0 unchanged.
- R4: A read strobe at any of 0xC058 to 0xC05B raises `sel_ack` in the same cycle, and `sel_rdata` is 0x00 while `sel_ack` is high; a write strobe there also changes the page.
- R5: The page does not change when there is no strobe, or when the strobe addresses anything other than 0xC058 to 0xC05B (for example 0xC057, 0xC05C or 0xD058).
- R6: `rom_valid` is high exactly for addresses 0xD000 to 0xFFFF. While it is high, `rom_addr` equals page × 0x3000 + (address − 0xD000). While it is low, `rom_addr`, `chip_sel` and `chip_addr` are 0.
- R7: While `rom_valid` is high, `chip_sel` is one-hot with bit k set, where k = (address − 0xD000) / 0x800, for k from 0 to 5.
- R8: `chip_addr` = w × 0x800 + (address & 0x7FF). The window w equals the page for an 8 KB chip and page mod 2 for a 4 KB chip. The chip sizes come from the `CHIP_BIG` mask, where bit k = 1 marks chip k as 8 KB; the default mask is 6'b110010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| sel_ack | output | 1 | High when a read hits a page switch location |
| sel_rdata | output | 8 | Read data returned for a page switch location (always zero) |
| page | output | 2 | Active ROM page |
| rom_valid | output | 1 | Address lies inside the ROM window |
| rom_addr | output | 16 | Flat physical ROM address |
| chip_sel | output | 6 | One-hot select of the chip holding the byte |
| chip_addr | output | 13 | Byte address inside the selected chip |

## Verification
The bench walks through all eight single-bit page transitions, using reads and writes in turn. A design that let one switch disturb the other bit, or that ignored one strobe type, would land on the wrong page.

It also strobes the neighbours just outside the switch range, the same low byte in the ROM window, and a switch location with no strobe. A decoder that is too wide or too loose would move the page on one of these.

For each page, the bench probes the first and last byte of each 2 KB slice and the addresses just below the window. This exposes three kinds of fault:
- an off-by-one slice boundary;
- a missing modulo for the 4 KB chips;
- a valid flag that stays high below 0xD000.

// File: rtl/rps_pkg.sv
package rps_pkg;
    localparam int PAGE_W = 2;

    typedef logic [PAGE_W-1:0] page_t;

    typedef struct packed {
        logic  hit;
        logic  set;
        page_t mask;
    } sw_cmd_t;

    typedef struct packed {
        page_t page;
    } page_state_t;
endpackage

// File: rtl/rps_decode.sv
module rps_decode
    import rps_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] IO_BASE = 16'hC000,
    parameter int                SW_OFF  = 'h58
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output sw_cmd_t           cmd,
    output logic              rd_ack
);
    localparam int NSW   = 2 * PAGE_W;
    localparam int IDX_W = $clog2(NSW);

    logic       in_io;
    logic [7:0] idx8;
    logic       in_range;

    always_comb begin
        in_io    = (addr[ADDR_W-1:8] == IO_BASE[ADDR_W-1:8]);
        idx8     = addr[7:0] - 8'(SW_OFF);
        in_range = in_io && (idx8 < 8'(NSW));
        cmd.hit  = in_range && (rd || wr);
        cmd.set  = idx8[0];
        for (int b = 0; b < PAGE_W; b++) begin
            cmd.mask[b] = (int'(idx8[IDX_W-1:1]) == b);
        end
        rd_ack = in_range && rd;
    end
endmodule

// File: rtl/rps_pagereg.sv
module rps_pagereg
    import rps_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  sw_cmd_t cmd,
    output page_t   page
);
    page_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (cmd.hit) begin
            if (cmd.set) state_d.page = state_q.page | cmd.mask;
            else         state_d.page = state_q.page & ~cmd.mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign page = state_q.page;
endmodule

// File: rtl/rps_map.sv
module rps_map
    import rps_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hD000,
    parameter int                CHIPS    = 6,
    parameter int                WIN_AW   = 11,
    parameter logic [CHIPS-1:0]  CHIP_BIG = 6'b110010,
    parameter int                ROM_AW   = 16,
    parameter int                CHIP_AW  = 13
) (
    input  logic [ADDR_W-1:0]  addr,
    input  page_t              page,
    output logic               valid,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic [CHIPS-1:0]   chip_sel,
    output logic [CHIP_AW-1:0] chip_addr
);
    localparam int SLICE_W    = $clog2(CHIPS);
    localparam int BANK_BYTES = CHIPS << WIN_AW;

    logic [ADDR_W-1:0]  off;
    logic [SLICE_W-1:0] slice;
    page_t              win_a [CHIPS];
    page_t              sel_win;

    assign off   = addr - WIN_BASE;
    assign valid = (addr >= WIN_BASE);
    assign slice = off[WIN_AW +: SLICE_W];

    for (genvar k = 0; k < CHIPS; k++) begin : g_chip
        if (CHIP_BIG[k]) begin : g_big
            assign win_a[k] = page;
        end else begin : g_small
            assign win_a[k] = PAGE_W'(page[0]);
        end
    end

    always_comb begin
        sel_win  = '0;
        chip_sel = '0;
        for (int k = 0; k < CHIPS; k++) begin
            if (slice == SLICE_W'(k)) begin
                sel_win     = win_a[k];
                chip_sel[k] = valid;
            end
        end
        if (valid) begin
            rom_addr  = ROM_AW'(page) * ROM_AW'(BANK_BYTES) + ROM_AW'(off);
            chip_addr = {sel_win, off[WIN_AW-1:0]};
        end else begin
            rom_addr  = '0;
            chip_addr = '0;
        end
    end
endmodule

// File: rtl/rom_page_sel.sv
module rom_page_sel
    import rps_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] IO_BASE  = 16'hC000,
    parameter int                SW_OFF   = 'h58,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hD000,
    parameter int                CHIPS    = 6,
    parameter int                WIN_AW   = 11,
    parameter logic [CHIPS-1:0]  CHIP_BIG = 6'b110010,
    localparam int               ROM_AW   = $clog2((CHIPS << WIN_AW) << PAGE_W),
    localparam int               CHIP_AW  = WIN_AW + PAGE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    output logic               sel_ack,
    output logic [DATA_W-1:0]  sel_rdata,
    output logic [PAGE_W-1:0]  page,
    output logic               rom_valid,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic [CHIPS-1:0]   chip_sel,
    output logic [CHIP_AW-1:0] chip_addr
);
    sw_cmd_t cmd;

    rps_decode #(
        .ADDR_W (ADDR_W),
        .IO_BASE(IO_BASE),
        .SW_OFF (SW_OFF)
    ) u_decode (
        .addr  (cpu_addr),
        .rd    (cpu_rd),
        .wr    (cpu_wr),
        .cmd   (cmd),
        .rd_ack(sel_ack)
    );

    rps_pagereg u_pagereg (
        .clk  (clk),
        .rst_n(rst_n),
        .cmd  (cmd),
        .page (page)
    );

    rps_map #(
        .ADDR_W  (ADDR_W),
        .WIN_BASE(WIN_BASE),
        .CHIPS   (CHIPS),
        .WIN_AW  (WIN_AW),
        .CHIP_BIG(CHIP_BIG),
        .ROM_AW  (ROM_AW),
        .CHIP_AW (CHIP_AW)
    ) u_map (
        .addr     (cpu_addr),
        .page     (page),
        .valid    (rom_valid),
        .rom_addr (rom_addr),
        .chip_sel (chip_sel),
        .chip_addr(chip_addr)
    );

    assign sel_rdata = '0;
endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] IO_BASE  = 16'hC000,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hD000,
    parameter int                CHIPS    = 6,
    parameter int                ROM_AW   = 16,
    parameter int                CHIP_AW  = 13
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  cpu_addr,
    input logic               cpu_rd,
    input logic               cpu_wr,
    input logic               sel_ack,
    input logic [DATA_W-1:0]  sel_rdata,
    input logic [1:0]         page,
    input logic               rom_valid,
    input logic [ROM_AW-1:0]  rom_addr,
    input logic [CHIPS-1:0]   chip_sel,
    input logic [CHIP_AW-1:0] chip_addr
);
    logic strobe;
    logic sw_range;
    assign strobe   = cpu_rd || cpu_wr;
    assign sw_range = (cpu_addr >= IO_BASE + 16'h58) && (cpu_addr <= IO_BASE + 16'h5B);

    always @(posedge clk) begin
        if (!rst_n) AST_RESET_PAGE: assert (page == 2'b00); // R1
    end

    AST_BIT0_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cpu_addr == IO_BASE + 16'h58) |=> (page[0] == 1'b0 && page[1] == $past(page[1]))); // R2
    AST_BIT0_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cpu_addr == IO_BASE + 16'h59) |=> (page[0] == 1'b1 && page[1] == $past(page[1]))); // R2
    AST_BIT1_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cpu_addr == IO_BASE + 16'h5A) |=> (page[1] == 1'b0 && page[0] == $past(page[0]))); // R3
    AST_BIT1_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cpu_addr == IO_BASE + 16'h5B) |=> (page[1] == 1'b1 && page[0] == $past(page[0]))); // R3
    AST_READ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && sw_range) |-> (sel_ack && sel_rdata == '0)); // R4
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe && sw_range) |=> $stable(page)); // R5
    AST_VALID_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rom_valid == (cpu_addr >= WIN_BASE)); // R6
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_valid |-> (rom_addr == '0 && chip_addr == '0)); // R6
    AST_CSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chip_sel) && (rom_valid == (chip_sel != '0))); // R7
endmodule

bind rom_page_sel rps_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .IO_BASE (IO_BASE),
    .WIN_BASE(WIN_BASE),
    .CHIPS   (CHIPS),
    .ROM_AW  (ROM_AW),
    .CHIP_AW (CHIP_AW)
) u_chk (.*);

// File: tb/sim_rom_page_sel.sv
module sim_rom_page_sel;
    localparam logic [5:0] BIG = 6'b110010;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic        cpu_rd, cpu_wr;
    logic        sel_ack;
    logic [7:0]  sel_rdata;
    logic [1:0]  page;
    logic        rom_valid;
    logic [15:0] rom_addr;
    logic [5:0]  chip_sel;
    logic [12:0] chip_addr;

    int tests = 0;
    int fails = 0;
    int model_page = 0;

    always #5 clk = ~clk;

    rom_page_sel u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .sel_ack(sel_ack), .sel_rdata(sel_rdata), .page(page), .rom_valid(rom_valid),
        .rom_addr(rom_addr), .chip_sel(chip_sel), .chip_addr(chip_addr)
    );

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // one strobe cycle; page model follows the requirement table
    task automatic touch(logic [15:0] a, bit rd, string req);
        @(negedge clk);
        cpu_addr = a; cpu_rd = rd; cpu_wr = !rd;
        #1;
        if (rd) begin
            chk({req, " R4 ack"}, int'(sel_ack), (a >= 16'hC058 && a <= 16'hC05B) ? 1 : 0);
            chk({req, " R4 rdata"}, int'(sel_rdata), 0);
        end
        case (a)
            16'hC058: model_page = model_page & 2;
            16'hC059: model_page = model_page | 1;
            16'hC05A: model_page = model_page & 1;
            16'hC05B: model_page = model_page | 2;
            default: ;
        endcase
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        #1;
        chk({req, " page"}, int'(page), model_page);
    endtask

    task automatic set_page(int p);
        touch((p & 1) ? 16'hC059 : 16'hC058, 1'b0, "R2");
        touch((p & 2) ? 16'hC05B : 16'hC05A, 1'b0, "R3");
    endtask

    task automatic probe(logic [15:0] a);
        int off, k, w;
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b0; cpu_wr = 1'b0;
        #1;
        if (a >= 16'hD000) begin
            off = int'(a) - 'hD000;
            k   = off / 'h800;
            w   = BIG[k] ? model_page : (model_page & 1);
            chk("R6 valid", int'(rom_valid), 1);
            chk("R6 rom_addr", int'(rom_addr), model_page * 'h3000 + off);
            chk("R7 chip_sel", int'(chip_sel), 1 << k);
            chk("R8 chip_addr", int'(chip_addr), w * 'h800 + (off & 'h7FF));
        end else begin
            chk("R6 valid low", int'(rom_valid), 0);
            chk("R6 rom_addr low", int'(rom_addr), 0);
            chk("R6 chip_sel low", int'(chip_sel), 0);
            chk("R6 chip_addr low", int'(chip_addr), 0);
        end
    endtask

    task automatic t_reset();
        chk("R1 page in reset", int'(page), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 page after reset", int'(page), 0);
        probe(16'hD000);
    endtask

    task automatic t_transitions();
        touch(16'hC059, 1'b1, "R2 0->1");
        touch(16'hC05B, 1'b0, "R3 1->3");
        touch(16'hC058, 1'b1, "R2 3->2");
        touch(16'hC05A, 1'b0, "R3 2->0");
        touch(16'hC05B, 1'b1, "R3 0->2");
        touch(16'hC059, 1'b0, "R2 2->3");
        touch(16'hC05A, 1'b1, "R3 3->1");
        touch(16'hC058, 1'b0, "R2 1->0");
        touch(16'hC058, 1'b1, "R2 clear when clear");
    endtask

    task automatic t_ignored();
        set_page(1);
        touch(16'hC057, 1'b1, "R5 below");
        touch(16'hC05C, 1'b0, "R5 above");
        touch(16'hD05B, 1'b1, "R5 rom alias");
        touch(16'hC15B, 1'b0, "R5 other io page");
        @(negedge clk);
        cpu_addr = 16'hC05B; cpu_rd = 1'b0; cpu_wr = 1'b0;
        @(negedge clk); #1;
        chk("R5 no strobe", int'(page), model_page);
    endtask

    task automatic t_mapping();
        for (int p = 0; p < 4; p++) begin
            set_page(p);
            for (int k = 0; k < 6; k++) begin
                probe(16'(32'hD000 + k * 'h800));
                probe(16'(32'hD000 + k * 'h800 + 'h7FF));
            end
        end
        probe(16'hCFFF);
        probe(16'h0000);
        probe(16'hC05B);
    endtask

    initial begin
        rst_n = 1'b0; cpu_addr = '0; cpu_rd = 1'b0; cpu_wr = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_transitions();
        t_ignored();
        t_mapping();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule